// File: doc/BRIEF.md
# Streaming Sub-Aperture Centroid Engine

This block finds the intensity-weighted mean position of the light in each sub-aperture image of a wavefront sensor. The image arrives as a stream of 16-bit unsigned pixels, packed four to a 64-bit beat in raster order. Each pixel is first passed through a weighting stage. The stage either uses the raw value or looks up a host-loaded table, which can apply for example a square or a 1.5 power law. The weighted values are then summed, along with their products with the column and row indices. When the last beat of a sub-aperture arrives, the two moment sums are divided by the total. The divider is a fully pipelined fixed-point unit with 16 fractional bits. The quotient is then shifted so that the middle of the sub-aperture reads zero, and converted to an IEEE-754 single-precision value.

The width and height of the sub-aperture are run-time settings, given as base-two logarithms. The pipeline takes one beat per cycle whatever the sub-aperture size, so even a 2x2 sub-aperture yields one x,y pair per cycle. A stall on the result port freezes the whole pipeline and drops the input ready.

Top module: `centroid_engine`

## Requirements
- R1: Lane k of a beat carries bits [16k+15:16k] and is pixel 4b+k of the sub-aperture, where b is the beat's position within the sub-aperture. Pixel p sits at column x = p mod Nx and row y = p div Nx.
- R2: Nx = 2^cfg_log_nx and Ny = 2^cfg_log_ny, each exponent from 1 to 5, with Nx*Ny >= 4. A sub-aperture spans Nx*Ny/4 beats. The configuration is sampled with every beat and must not change inside a sub-aperture.
- R3: Let W be the sum of the weights, and Mx and My the sums of weight*x and weight*y. Then q = floor(M*2^16/W) and c = q - (N-1)*2^15 for the matching axis. res_x and res_y equal c/2^16 as an exact single-precision value (+0.0 for c = 0).
- R4: When W is zero, res_x and res_y are both 32'h00000000.
- R5: With cfg_map_en low, a pixel's weight is its value. With it high, the weight is the 32-bit table entry addressed by pixel bits [15:10].
- R6: After reset, table entry i holds i*1024.
- R7: A write with cfg_map_we high stores cfg_map_data at entry cfg_map_addr on that clock edge, and applies to every beat accepted afterwards.
- R8: While res_ready is high, pix_ready stays high and one beat is taken per cycle.
- R9: With the pipeline idle and res_ready high, res_valid for a sub-aperture rises 23 cycles after the edge that accepts its last beat.
- R10: While res_valid is high and res_ready low, res_valid, res_x and res_y hold, pix_ready is low, and no result is lost or reordered.
- R11: After reset, res_valid is low and pix_ready is high.
- R12: Every result has magnitude at most (N-1)/2, so its exponent field never exceeds 127+MAX_LOG-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_log_nx | input | 3 | log2 of sub-aperture width |
| cfg_log_ny | input | 3 | log2 of sub-aperture height |
| cfg_map_en | input | 1 | Use the weighting table instead of raw pixels |
| cfg_map_we | input | 1 | Weighting table write strobe |
| cfg_map_addr | input | 6 | Weighting table write index |
| cfg_map_data | input | 32 | Weighting table write value |
| pix_valid | input | 1 | Input beat valid |
| pix_ready | output | 1 | Input beat accepted when high with pix_valid |
| pix_data | input | 64 | Four 16-bit pixels, lane 0 lowest |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken when high with res_valid |
| res_x | output | 32 | Centred x centroid, single precision |
| res_y | output | 32 | Centred y centroid, single precision |

## Verification
A result passes through one weighting register, one accumulation register, 21 divider stages and one output register. So it is due 23 cycles after the edge that accepts the last beat of its sub-aperture. The bench records that edge and checks that res_valid rises on exactly that cycle for an isolated sub-aperture. In all other runs each result is matched in order against a queue of expected pairs, and the comparison is made only in the cycle where res_valid and res_ready are both high. Inputs are driven and outputs sampled on the falling edge, and a beat counts as sent only when pix_ready was high at that sample, so stalls shift the timing without breaking the comparison.

// File: rtl/centroid_pkg.sv
`timescale 1ns/1ps
package centroid_pkg;

  localparam int PIX_W = 16;
  localparam int FRAC  = 16;

  // Exact conversion of a signed fixed-point value with 'frac' fractional
  // bits into single precision (truncates only beyond 24 significant bits).
  function automatic logic [31:0] fix_to_f32(input logic signed [31:0] v, input int frac);
    logic [31:0] mag;
    logic [31:0] man;
    logic [7:0]  ex;
    int          msb;
    if (v == 0) return 32'h0;
    mag = v[31] ? 32'(-v) : 32'(v);
    msb = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) msb = i;
    ex = 8'(127 + msb - frac);
    if (msb <= 23) man = mag << (23 - msb);
    else           man = mag >> (msb - 23);
    return {v[31], ex, man[22:0]};
  endfunction

endpackage

// File: rtl/cen_weight_map.sv
`timescale 1ns/1ps
module cen_weight_map #(
  parameter int PIX_W  = 16,
  parameter int LANES  = 4,
  parameter int TBL_AW = 6,
  parameter int WGT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          map_en,
  input  logic                          we,
  input  logic [TBL_AW-1:0]             waddr,
  input  logic [WGT_W-1:0]              wdata,
  input  logic [LANES-1:0][PIX_W-1:0]   pix,
  output logic [LANES-1:0][WGT_W-1:0]   wgt
);
  localparam int DEPTH = 1 << TBL_AW;
  localparam int SHIFT = PIX_W - TBL_AW;

  logic [WGT_W-1:0] tbl [DEPTH];

  // Table: identity-shaped reset, host writes at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= WGT_W'(i) << SHIFT;
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WGT_W-1:0] w_next;
    assign w_next = map_en ? tbl[pix[k][PIX_W-1 -: TBL_AW]] : WGT_W'(pix[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wgt[k] <= '0;
      else if (en) wgt[k] <= w_next;
    end
  end
endmodule

// File: rtl/cen_accum.sv
`timescale 1ns/1ps
module cen_accum #(
  parameter int LANES = 4,
  parameter int WGT_W = 32,
  parameter int CRD_W = 5,
  parameter int SUM_W = 42,
  parameter int MOM_W = 47
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        in_valid,
  input  logic                        in_last,
  input  logic [LANES-1:0][WGT_W-1:0] wgt,
  input  logic [LANES-1:0][CRD_W-1:0] xc,
  input  logic [LANES-1:0][CRD_W-1:0] yc,
  output logic                        done,
  output logic [SUM_W-1:0]            tot_w,
  output logic [MOM_W-1:0]            tot_x,
  output logic [MOM_W-1:0]            tot_y
);
  logic [SUM_W-1:0] acc_w, beat_w;
  logic [MOM_W-1:0] acc_x, acc_y, beat_x, beat_y;

  always_comb begin
    beat_w = '0;
    beat_x = '0;
    beat_y = '0;
    for (int k = 0; k < LANES; k++) begin
      beat_w = beat_w + SUM_W'(wgt[k]);
      beat_x = beat_x + MOM_W'(wgt[k]) * MOM_W'(xc[k]);
      beat_y = beat_y + MOM_W'(wgt[k]) * MOM_W'(yc[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_w <= '0; acc_x <= '0; acc_y <= '0;
      tot_w <= '0; tot_x <= '0; tot_y <= '0;
      done  <= 1'b0;
    end else if (en) begin
      done <= in_valid && in_last;
      if (in_valid && in_last) begin
        tot_w <= acc_w + beat_w;
        tot_x <= acc_x + beat_x;
        tot_y <= acc_y + beat_y;
        acc_w <= '0; acc_x <= '0; acc_y <= '0;
      end else if (in_valid) begin
        acc_w <= acc_w + beat_w;
        acc_x <= acc_x + beat_x;
        acc_y <= acc_y + beat_y;
      end
    end
  end
endmodule

// File: rtl/cen_divider.sv
`timescale 1ns/1ps
module cen_divider #(
  parameter int DIV_W = 63,
  parameter int DEN_W = 42,
  parameter int QW    = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [QW-1:0]    quo
);
  // One restoring step per stage, most significant quotient bit first.
  for (genvar j = 0; j < QW; j++) begin : g_stage
    localparam int SH = QW - 1 - j;
    logic [DIV_W-1:0] rem_i, trial, rem_q;
    logic [DEN_W-1:0] den_i, den_q;
    logic [QW-1:0]    q_i, q_q;
    logic             fits;

    if (j == 0) begin : g_first
      assign rem_i = num;
      assign den_i = den;
      assign q_i   = '0;
    end else begin : g_next
      assign rem_i = g_stage[j-1].rem_q;
      assign den_i = g_stage[j-1].den_q;
      assign q_i   = g_stage[j-1].q_q;
    end

    assign trial = DIV_W'(den_i) << SH;
    assign fits  = rem_i >= trial;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem_q <= '0; den_q <= '0; q_q <= '0;
      end else if (en) begin
        rem_q <= fits ? rem_i - trial : rem_i;
        den_q <= den_i;
        q_q   <= q_i | (fits ? (QW'(1) << SH) : QW'(0));
      end
    end
  end

  assign quo = g_stage[QW-1].q_q;
endmodule

// File: rtl/centroid_engine.sv
`timescale 1ns/1ps
module centroid_engine #(
  parameter int LANES   = 4,
  parameter int MAX_LOG = 5,
  parameter int TBL_AW  = 6,
  parameter int WGT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cfg_log_nx,
  input  logic [2:0]               cfg_log_ny,
  input  logic                     cfg_map_en,
  input  logic                     cfg_map_we,
  input  logic [TBL_AW-1:0]        cfg_map_addr,
  input  logic [WGT_W-1:0]         cfg_map_data,
  input  logic                     pix_valid,
  output logic                     pix_ready,
  input  logic [LANES*16-1:0]      pix_data,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [31:0]              res_x,
  output logic [31:0]              res_y
);
  import centroid_pkg::*;

  localparam int LANE_W = $clog2(LANES);
  localparam int CRD_W  = MAX_LOG;
  localparam int IDX_W  = 2 * MAX_LOG;
  localparam int BCNT_W = IDX_W - LANE_W;
  localparam int SUM_W  = WGT_W + 2 * MAX_LOG;
  localparam int MOM_W  = SUM_W + MAX_LOG;
  localparam int DIV_W  = MOM_W + FRAC;
  localparam int QW     = MAX_LOG + FRAC;

  typedef struct packed {
    logic       valid;
    logic       zero;
    logic [2:0] lnx;
    logic [2:0] lny;
  } side_t;

  // Flow control: the whole pipeline advances unless a result is stuck.
  logic adv, accept, beat_last;
  assign adv       = !res_valid || res_ready;
  assign pix_ready = adv;
  assign accept    = pix_valid && adv;

  // Beat position inside the current sub-aperture.
  logic [BCNT_W-1:0] bcnt, beats_m1;
  assign beats_m1  = BCNT_W'((1 << (int'(cfg_log_nx) + int'(cfg_log_ny) - LANE_W)) - 1);
  assign beat_last = bcnt == beats_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bcnt <= '0;
    else if (accept) bcnt <= beat_last ? '0 : bcnt + 1'b1;
  end

  // Stage 0: coordinates and weights registered together.
  logic [LANES-1:0][PIX_W-1:0] lane_pix;
  logic [LANES-1:0][CRD_W-1:0] xc_n, yc_n, s0_xc, s0_yc;
  logic [LANES-1:0][WGT_W-1:0] s0_wgt;
  logic                        s0_valid, s0_last;
  logic [2:0]                  s0_lnx, s0_lny;

  for (genvar k = 0; k < LANES; k++) begin : g_crd
    logic [IDX_W-1:0] pidx;
    assign lane_pix[k] = pix_data[k*PIX_W +: PIX_W];
    assign pidx        = {bcnt, LANE_W'(k)};
    assign xc_n[k]     = CRD_W'(pidx & ((IDX_W'(1) << cfg_log_nx) - 1'b1));
    assign yc_n[k]     = CRD_W'(pidx >> cfg_log_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_valid <= 1'b0; s0_last <= 1'b0;
      s0_xc <= '0; s0_yc <= '0; s0_lnx <= '0; s0_lny <= '0;
    end else if (adv) begin
      s0_valid <= accept;
      s0_last  <= beat_last;
      s0_xc    <= xc_n;
      s0_yc    <= yc_n;
      s0_lnx   <= cfg_log_nx;
      s0_lny   <= cfg_log_ny;
    end
  end

  cen_weight_map #(.PIX_W(PIX_W), .LANES(LANES), .TBL_AW(TBL_AW), .WGT_W(WGT_W)) i_wmap (
    .clk(clk), .rst_n(rst_n), .en(adv), .map_en(cfg_map_en),
    .we(cfg_map_we), .waddr(cfg_map_addr), .wdata(cfg_map_data),
    .pix(lane_pix), .wgt(s0_wgt)
  );

  // Stage 1: moment accumulation.
  logic             sum_done;
  logic [SUM_W-1:0] tot_w;
  logic [MOM_W-1:0] tot_x, tot_y;
  logic [2:0]       s1_lnx, s1_lny;

  cen_accum #(.LANES(LANES), .WGT_W(WGT_W), .CRD_W(CRD_W), .SUM_W(SUM_W), .MOM_W(MOM_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(s0_valid), .in_last(s0_last),
    .wgt(s0_wgt), .xc(s0_xc), .yc(s0_yc),
    .done(sum_done), .tot_w(tot_w), .tot_x(tot_x), .tot_y(tot_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lnx <= '0; s1_lny <= '0;
    end else if (adv) begin
      s1_lnx <= s0_lnx;
      s1_lny <= s0_lny;
    end
  end

  // Divider stages, one per axis, with a matching sideband pipe.
  logic [1:0][MOM_W-1:0] mom;
  logic [1:0][QW-1:0]    quo;
  assign mom[0] = tot_x;
  assign mom[1] = tot_y;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    cen_divider #(.DIV_W(DIV_W), .DEN_W(SUM_W), .QW(QW)) i_div (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .num({mom[a], FRAC'(0)}), .den(tot_w), .quo(quo[a])
    );
  end

  side_t side [QW];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QW; i++) side[i] <= '0;
    end else if (adv) begin
      side[0] <= '{valid: sum_done, zero: tot_w == '0, lnx: s1_lnx, lny: s1_lny};
      for (int i = 1; i < QW; i++) side[i] <= side[i-1];
    end
  end

  // Output stage: centre offset and float conversion.
  logic                 out_load, out_zero;
  logic [QW-1:0]        off_x, off_y;
  logic signed [QW:0]   cx, cy;
  assign out_load = adv && side[QW-1].valid;
  assign out_zero = side[QW-1].zero;
  assign off_x    = ((QW'(1) << side[QW-1].lnx) - 1'b1) << (FRAC - 1);
  assign off_y    = ((QW'(1) << side[QW-1].lny) - 1'b1) << (FRAC - 1);
  assign cx       = $signed({1'b0, quo[0]}) - $signed({1'b0, off_x});
  assign cy       = $signed({1'b0, quo[1]}) - $signed({1'b0, off_y});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_x <= '0; res_y <= '0;
    end else if (adv) begin
      res_valid <= side[QW-1].valid;
      if (side[QW-1].valid) begin
        res_x <= out_zero ? 32'h0 : fix_to_f32(32'(cx), FRAC);
        res_y <= out_zero ? 32'h0 : fix_to_f32(32'(cy), FRAC);
      end
    end
  end
endmodule

// File: rtl/cen_checker.sv
`timescale 1ns/1ps
module cen_checker #(
  parameter int MAX_LOG = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_ready,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_x,
  input logic [31:0] res_y,
  input logic        out_load,
  input logic        out_zero
);
  localparam logic [7:0] EXP_MAX = 8'(127 + MAX_LOG - 2);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_x) && $stable(res_y));

  assert_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !pix_ready);

  assert_flow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> pix_ready);

  assert_zero_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_load && out_zero |=> res_x == 32'h0 && res_y == 32'h0);

  assert_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_x[30:23] <= EXP_MAX && res_y[30:23] <= EXP_MAX);
endmodule

bind centroid_engine cen_checker #(.MAX_LOG(MAX_LOG)) i_cen_checker (
  .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_x(res_x), .res_y(res_y),
  .out_load(out_load), .out_zero(out_zero)
);

// File: tb/test_centroid_engine.sv
`timescale 1ns/1ps
module test_centroid_engine;
  localparam int LAT = 2 + 5 + 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_log_nx = 3'd2, cfg_log_ny = 3'd2;
  logic        cfg_map_en = 1'b0, cfg_map_we = 1'b0;
  logic [5:0]  cfg_map_addr = '0;
  logic [31:0] cfg_map_data = '0;
  logic        pix_valid = 1'b0, res_ready = 1'b1;
  logic [63:0] pix_data = '0;
  logic        pix_ready, res_valid;
  logic [31:0] res_x, res_y;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] lut_m [64];
  logic [31:0] qx [$];
  logic [31:0] qy [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  centroid_engine i_centroid_engine (
    .clk(clk), .rst_n(rst_n), .cfg_log_nx(cfg_log_nx), .cfg_log_ny(cfg_log_ny),
    .cfg_map_en(cfg_map_en), .cfg_map_we(cfg_map_we), .cfg_map_addr(cfg_map_addr),
    .cfg_map_data(cfg_map_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_x(res_x), .res_y(res_y)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] pix_of(input int pat, input int s, input int p, input int tot);
    int unsigned h;
    h = 32'(s) * 32'd7919 + 32'(p) * 32'd104729 + 32'd17;
    h = h ^ (h << 13); h = h ^ (h >> 17); h = h ^ (h << 5);
    case (pat)
      0:       return (p == s % tot) ? 16'(1000 + s * 37) : 16'h0;
      1:       return h[15:0];
      2:       return 16'h0;
      3:       return 16'hFFFF;
      default: return {8'h0, h[7:0]};
    endcase
  endfunction

  // Exact fixed-point value with 16 fractional bits, via double precision.
  function automatic logic [31:0] ref_f32(input longint c);
    logic [63:0] d;
    int e;
    if (c == 0) return 32'h0;
    d = $realtobits(real'(c) / 65536.0);
    e = int'(d[62:52]) - 1023 + 127;
    return {d[63], 8'(e), d[51:29]};
  endfunction

  task automatic ref_pair(input int pat, input int s, input int lnx, input int lny,
                          input bit men, output logic [31:0] fx, output logic [31:0] fy);
    longint unsigned sw = 0, sx = 0, sy = 0, w;
    int tot = 1 << (lnx + lny);
    int nx = 1 << lnx;
    for (int p = 0; p < tot; p++) begin
      logic [15:0] px = pix_of(pat, s, p, tot);
      w  = men ? longint'(lut_m[px >> 10]) : longint'(px);
      sw += w;
      sx += w * longint'(p % nx);
      sy += w * longint'(p / nx);
    end
    if (sw == 0) begin
      fx = 32'h0; fy = 32'h0;
    end else begin
      fx = ref_f32(longint'((sx << 16) / sw) - longint'(nx - 1) * 32768);
      fy = ref_f32(longint'((sy << 16) / sw) - longint'((1 << lny) - 1) * 32768);
    end
  endtask

  task automatic play(input int nsub, input int lnx, input int lny, input int pat,
                      input bit men, input int rmode, input bit lat, input string req);
    int tot = 1 << (lnx + lny);
    int bps = tot / 4;
    int s = 0, b = 0, acc_edge = 0;
    bit seen = 1'b0;
    logic [31:0] ex, ey;
    @(negedge clk);
    cfg_log_nx = 3'(lnx); cfg_log_ny = 3'(lny); cfg_map_en = men;
    forever begin
      res_ready = (rmode == 0) ? 1'b1 : (cyc % 3 != 0);
      #1;
      if (res_valid) begin
        if (lat && !seen) begin
          seen = 1'b1;
          check(cyc == acc_edge + LAT, "R9", cyc - acc_edge, LAT);
        end
        if (res_ready) begin
          if (qx.size() == 0) check(1'b0, req, res_x, 0);
          else begin
            ex = qx.pop_front(); ey = qy.pop_front();
            check(res_x == ex, {req, " x"}, res_x, ex);
            check(res_y == ey, {req, " y"}, res_y, ey);
          end
        end else check(!pix_ready, "R10 stall", pix_ready, 0);
      end
      if (s < nsub) begin
        pix_valid = 1'b1;
        for (int k = 0; k < 4; k++) pix_data[16*k +: 16] = pix_of(pat, s, b * 4 + k, tot);
        if (rmode == 0) check(pix_ready, "R8", pix_ready, 1);
        if (pix_ready) begin
          if (b == bps - 1) begin
            ref_pair(pat, s, lnx, lny, men, ex, ey);
            qx.push_back(ex); qy.push_back(ey);
            acc_edge = cyc + 1;
            b = 0; s++;
          end else b++;
        end
      end else pix_valid = 1'b0;
      if (s >= nsub && qx.size() == 0 && !res_valid) break;
      @(negedge clk);
    end
    res_ready = 1'b1;
  endtask

  task automatic load_squares();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      lut_m[i]     = 32'(i * 1024) * 32'(i * 1024);
      cfg_map_we   = 1'b1;
      cfg_map_addr = 6'(i);
      cfg_map_data = lut_m[i];
    end
    @(negedge clk);
    cfg_map_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R8 watchdog expired, run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) lut_m[i] = 32'(i * 1024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_valid, "R11 res_valid", res_valid, 0);
    check(pix_ready, "R11 pix_ready", pix_ready, 1);

    play(1, 1, 1, 1, 0, 0, 1, "R9");             // latency from an idle pipeline
    play(16, 2, 2, 0, 0, 0, 0, "R1");            // spot at every 4x4 position
    play(16, 1, 3, 0, 0, 0, 0, "R1");            // spot at every 2x8 position
    play(4, 1, 1, 1, 0, 0, 0, "R2");             // smallest, one result per beat
    play(4, 3, 2, 1, 0, 0, 0, "R2");
    play(3, 1, 5, 1, 0, 0, 0, "R2");
    play(3, 5, 1, 1, 0, 0, 0, "R2");
    play(2, 5, 5, 1, 0, 0, 0, "R3");
    play(2, 5, 5, 3, 0, 0, 0, "R3");             // full-scale pixels
    play(3, 2, 3, 2, 0, 0, 0, "R4");             // empty image
    play(8, 2, 2, 1, 1, 0, 0, "R6");             // default table
    load_squares();
    play(8, 3, 3, 1, 1, 0, 0, "R7");             // loaded table applies
    play(2, 5, 5, 3, 1, 0, 0, "R5");             // largest weighted sums
    play(6, 2, 2, 4, 1, 0, 0, "R5");             // small pixels map to zero weight
    play(6, 2, 2, 1, 0, 0, 0, "R5 raw");         // bypass after load
    play(20, 1, 2, 1, 0, 1, 0, "R10");           // back-pressure, raw
    play(10, 3, 2, 1, 1, 1, 0, "R10");           // back-pressure, mapped

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule